// File: doc/BRIEF.md
# Streaming Multiply-Accumulate Unit

This block forms a running sum of products from a stream of signed 16-bit operand pairs. A new pair may be presented on every clock, with no stall and no handshake. A three-stage pipelined 16x16 signed multiplier feeds a one-stage accumulator, so each pair shows up in the sum four cycles after it enters.

Each pair carries a valid flag and two markers. One marker opens a sequence and the other closes it. The opening marker travels down the multiplier pipeline next to its operands. When its product reaches the accumulator, that product is loaded in place of the old contents, so no clear cycle is needed between sequences. The closing marker travels the same way and raises a one-cycle done pulse in the cycle that the complete sum is on the output.

The accumulator is 40 bits wide: the 32-bit product plus 8 guard bits. Products are sign-extended before they are added. A datapath or filter engine uses the block by streaming its coefficient and sample pairs, marking the first and last pair of each dot product, and capturing the accumulator on the done pulse.

Top module: `mac_stream`

## Requirements
- R1: A clock edge with rst_n low (synchronous, active-low) clears the block. From the next cycle, acc_out is 0, acc_vld is 0, seq_done is 0, and pairs that were still in the pipeline never reach the sum.
- R2: A pair is accepted on every clock with no stall. The pair presented in cycle k affects acc_out, acc_vld and seq_done first in cycle k+4: three multiplier stages, then one accumulator stage.
- R3: A pair with in_vld=1 and in_sos=1 starts a sequence. Four cycles later, acc_out equals that pair's product sign-extended to 40 bits, whatever the accumulator held before.
- R4: A pair with in_vld=1 and in_sos=0 adds its product to acc_out four cycles later. op_a and op_b are two's-complement signed values, and the product is sign-extended from 32 to 40 bits before the add.
- R5: A cycle with in_vld=0 is a bubble. Four cycles later, acc_out keeps its previous value and acc_vld is 0. The operand and marker values presented with a bubble have no effect.
- R6: seq_done is high for one cycle, in cycle k+4, where k is the cycle of a valid pair with in_eos=1. In that cycle acc_out holds the sum of all valid products from the opening pair through that pair, and acc_vld is also high. A valid pair carrying both markers forms a one-pair sequence.
- R7: A new sequence may open in the cycle right after the previous one closes. Both sums are correct, with no idle cycle between them. A sequence of N pairs in consecutive cycles 0..N-1 has its sum in cycle N+3.
- R8: acc_vld is high in cycle k+4 exactly when a valid pair was presented in cycle k. In particular, acc_vld stays low for the first four cycles after reset, even if valid pairs arrive at once.
- R9: The 8 guard bits keep sums exact beyond the 32-bit product range. Examples: the single product (-32768)*(-32768) = 2^30, 300 of those summed, and 300 products of (-32768)*32767 summed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | The operand pair in this cycle is valid |
| in_sos | input | 1 | This pair opens a sequence (used only with in_vld) |
| in_eos | input | 1 | This pair closes a sequence (used only with in_vld) |
| op_a | input | 16 | Signed first operand |
| op_b | input | 16 | Signed second operand |
| acc_out | output | 40 | Accumulator value, two's complement |
| acc_vld | output | 1 | acc_out took in a valid product this cycle |
| seq_done | output | 1 | acc_out holds a completed sequence sum |

## Verification
Directed patterns try each input case in turn. Extreme operands at every sign combination test the split signed multiplier. Bubbles that carry random operands and stray markers show whether invalid cycles leak into the sum. Sequences that open in the cycle right after the previous one closes show whether the load is placed correctly and not one cycle early or late. One-pair sequences exercise both markers on the same pair. Long runs of maximum-magnitude products, positive and negative, show whether the guard bits carry the sum past 32 bits. Randomly sized sequences with random gaps compare every cycle of acc_out, acc_vld and seq_done against a cycle model, and compare each final sum and its arrival cycle against a running sum kept per sequence. A reset in the middle of a sequence shows that in-flight pairs are dropped.

// File: rtl/mac_pkg.sv
// Package: shared constants and types for the streaming MAC.
// Assumes: the multiplier in mac_mul_pipe has exactly MUL_STAGES register stages.
package mac_pkg;

    // Register stages between the operand ports and the product output.
    localparam int MUL_STAGES = 3;

    // Per-pair control that travels alongside the operands.
    typedef struct packed {
        logic vld;
        logic sos;
        logic eos;
    } mac_tag_t;

endpackage

// File: rtl/mac_mul_pipe.sv
// Module: signed A_W x B_W multiplier with three register stages.
// Stage 1 registers the operands. Stage 2 forms two partial products, one
// from the low half of B (taken as unsigned) and one from the high half
// (taken as signed). Stage 3 shifts the high partial product and adds it
// to the low one to give the full two's-complement product.
// Assumes: A_W >= 2, B_W >= 4. The latency is fixed at mac_pkg::MUL_STAGES.
module mac_mul_pipe #(
    parameter int A_W = 16,
    parameter int B_W = 16,
    localparam int P_W = A_W + B_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    output logic [P_W-1:0] prod
);

    localparam int LO_W = B_W / 2;
    localparam int HI_W = B_W - LO_W;
    localparam int PL_W = A_W + LO_W + 1;
    localparam int PH_W = A_W + HI_W;

    logic [A_W-1:0]         a_q;
    logic [B_W-1:0]         b_q;
    logic signed [PL_W-1:0] pl_q;
    logic signed [PH_W-1:0] ph_q;
    logic [P_W-1:0]         prod_q;

    logic signed [PL_W-1:0] a_xl, b_xl, pl_d;
    logic signed [PH_W-1:0] a_xh, b_xh, ph_d;
    logic [P_W-1:0]         pl_ext, ph_ext, sum_d;

    // Partial products: A times the unsigned low half and the signed high half of B.
    always_comb begin
        a_xl = {{(PL_W - A_W){a_q[A_W-1]}}, a_q};
        b_xl = {{(PL_W - LO_W){1'b0}}, b_q[LO_W-1:0]};
        pl_d = a_xl * b_xl;
        a_xh = {{(PH_W - A_W){a_q[A_W-1]}}, a_q};
        b_xh = {{(PH_W - HI_W){b_q[B_W-1]}}, b_q[B_W-1:LO_W]};
        ph_d = a_xh * b_xh;
    end

    // Combine: the high partial product is weighted by 2^LO_W.
    always_comb begin
        pl_ext = {{(P_W - PL_W){pl_q[PL_W-1]}}, pl_q};
        ph_ext = {{(P_W - PH_W){ph_q[PH_W-1]}}, ph_q};
        sum_d  = (ph_ext << LO_W) + pl_ext;
    end

    // Stage 1: capture the operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            a_q <= a_in;
            b_q <= b_in;
        end
    end

    // Stage 2: hold the two partial products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pl_q <= '0;
            ph_q <= '0;
        end else begin
            pl_q <= pl_d;
            ph_q <= ph_d;
        end
    end

    // Stage 3: hold the full product.
    always_ff @(posedge clk) begin
        if (!rst_n) prod_q <= '0;
        else        prod_q <= sum_d;
    end

    assign prod = prod_q;

endmodule

// File: rtl/mac_tag_pipe.sv
// Module: delay line that carries a pair's valid flag and markers, so they
// leave in the same cycle as that pair's product.
// Assumes: DEPTH matches the multiplier's register count.
module mac_tag_pipe
    import mac_pkg::*;
#(
    parameter int DEPTH = MUL_STAGES
) (
    input  logic     clk,
    input  logic     rst_n,
    input  mac_tag_t tag_in,
    output mac_tag_t tag_out
);

    mac_tag_t stg [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            // First stage: capture the incoming control.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= tag_in;
            end
        end else begin : g_body
            // Later stages: shift by one cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign tag_out = stg[DEPTH-1];

endmodule

// File: rtl/mac_acc.sv
// Module: guarded accumulator. A valid product that opens a sequence is
// loaded. A later valid product is added. A bubble leaves the sum alone.
// Assumes: the product and its tag arrive in the same cycle.
module mac_acc
    import mac_pkg::*;
#(
    parameter int P_W = 32,
    parameter int G_W = 8,
    localparam int ACC_W = P_W + G_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [P_W-1:0]   prod,
    input  mac_tag_t         tag,
    output logic [ACC_W-1:0] acc,
    output logic             acc_vld,
    output logic             done
);

    logic [ACC_W-1:0] prod_x;
    logic [ACC_W-1:0] acc_q;
    logic             vld_q, done_q;

    // Sign-extend the product into the guard bits.
    always_comb prod_x = {{G_W{prod[P_W-1]}}, prod};

    // Load on a sequence opener, add otherwise, hold on a bubble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            vld_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            vld_q  <= tag.vld;
            done_q <= tag.vld && tag.eos;
            if (tag.vld) acc_q <= tag.sos ? prod_x : acc_q + prod_x;
        end
    end

    assign acc     = acc_q;
    assign acc_vld = vld_q;
    assign done    = done_q;

endmodule

// File: rtl/mac_stream.sv
// Module: streaming multiply-accumulate top. Pipelined multiplier plus
// control delay line plus guarded accumulator. Latency from input to sum
// is MUL_STAGES + 1 cycles, one pair accepted per clock.
// Assumes: the markers are meaningful only on cycles with in_vld high.
module mac_stream
    import mac_pkg::*;
#(
    parameter int A_W     = 16,
    parameter int B_W     = 16,
    parameter int GUARD_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_vld,
    input  logic                       in_sos,
    input  logic                       in_eos,
    input  logic [A_W-1:0]             op_a,
    input  logic [B_W-1:0]             op_b,
    output logic [A_W+B_W+GUARD_W-1:0] acc_out,
    output logic                       acc_vld,
    output logic                       seq_done
);

    localparam int P_W = A_W + B_W;

    logic [P_W-1:0] mul_prod;
    mac_tag_t       tag_in, tag_mul;

    // Bundle the per-pair control for the delay line.
    always_comb tag_in = '{vld: in_vld, sos: in_sos, eos: in_eos};

    mac_mul_pipe #(.A_W(A_W), .B_W(B_W)) u_mul (
        .clk  (clk),
        .rst_n(rst_n),
        .a_in (op_a),
        .b_in (op_b),
        .prod (mul_prod)
    );

    mac_tag_pipe #(.DEPTH(MUL_STAGES)) u_tag (
        .clk    (clk),
        .rst_n  (rst_n),
        .tag_in (tag_in),
        .tag_out(tag_mul)
    );

    mac_acc #(.P_W(P_W), .G_W(GUARD_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .prod   (mul_prod),
        .tag    (tag_mul),
        .acc    (acc_out),
        .acc_vld(acc_vld),
        .done   (seq_done)
    );

endmodule

// File: rtl/mac_stream_chk.sv
// Module: property checker for mac_stream. It keeps its own four-cycle
// history of the inputs and a reference product, and relates the outputs to it.
// Assumes: it is attached through the bind at the end of this file.
module mac_stream_chk #(
    parameter int A_W = 16,
    parameter int B_W = 16,
    parameter int G_W = 8,
    localparam int ACC_W = A_W + B_W + G_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic             in_sos,
    input logic             in_eos,
    input logic [A_W-1:0]   op_a,
    input logic [B_W-1:0]   op_b,
    input logic [ACC_W-1:0] acc_out,
    input logic             acc_vld,
    input logic             seq_done
);

    localparam int HD = 4;

    logic                    h_vld [HD];
    logic                    h_sos [HD];
    logic                    h_eos [HD];
    logic signed [ACC_W-1:0] h_ref [HD];
    logic signed [ACC_W-1:0] xa, xb, ref_now;

    // Reference product at full accumulator width.
    always_comb begin
        xa      = {{(ACC_W - A_W){op_a[A_W-1]}}, op_a};
        xb      = {{(ACC_W - B_W){op_b[B_W-1]}}, op_b};
        ref_now = xa * xb;
    end

    // Input history, index HD-1 is four cycles old.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HD; i++) begin
                h_vld[i] <= 1'b0;
                h_sos[i] <= 1'b0;
                h_eos[i] <= 1'b0;
                h_ref[i] <= '0;
            end
        end else begin
            h_vld[0] <= in_vld;
            h_sos[0] <= in_sos;
            h_eos[0] <= in_eos;
            h_ref[0] <= ref_now;
            for (int i = 1; i < HD; i++) begin
                h_vld[i] <= h_vld[i-1];
                h_sos[i] <= h_sos[i-1];
                h_eos[i] <= h_eos[i-1];
                h_ref[i] <= h_ref[i-1];
            end
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (acc_out == '0 && !acc_vld && !seq_done));

    p_valid_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld == h_vld[HD-1]);

    p_first_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (h_vld[HD-1] && h_sos[HD-1]) |-> acc_out == h_ref[HD-1]);

    p_accumulate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (h_vld[HD-1] && !h_sos[HD-1] && $past(rst_n)) |->
            acc_out == $past(acc_out) + h_ref[HD-1]);

    p_bubble_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_vld[HD-1] && $past(rst_n)) |-> $stable(acc_out));

    p_done_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done == (h_vld[HD-1] && h_eos[HD-1]));

    p_done_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> acc_vld);

endmodule

bind mac_stream mac_stream_chk #(.A_W(A_W), .B_W(B_W), .G_W(GUARD_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_sos  (in_sos),
    .in_eos  (in_eos),
    .op_a    (op_a),
    .op_b    (op_b),
    .acc_out (acc_out),
    .acc_vld (acc_vld),
    .seq_done(seq_done)
);

// File: tb/tb_mac_stream.sv
module tb_mac_stream;

    localparam int ACC_W = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_vld = 1'b0, in_sos = 1'b0, in_eos = 1'b0;
    logic [15:0]      op_a = '0, op_b = '0;
    logic [ACC_W-1:0] acc_out;
    logic             acc_vld, seq_done;

    mac_stream dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sos(in_sos),
        .in_eos(in_eos), .op_a(op_a), .op_b(op_b),
        .acc_out(acc_out), .acc_vld(acc_vld), .seq_done(seq_done)
    );

    always #4ns clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    // Cycle model state and input history (index 3 is three cycles old).
    logic [ACC_W-1:0] m_acc = '0;
    logic             m_vld = 1'b0, m_done = 1'b0;
    logic             h_v [4];
    logic             h_s [4];
    logic             h_e [4];
    logic [ACC_W-1:0] h_p [4];

    // Per-sequence expected sums and arrival cycles.
    logic [ACC_W-1:0] q_sum [64];
    int               q_cyc [64];
    int               q_wr = 0, q_rd = 0;
    logic [ACC_W-1:0] r_sum = '0;

    function automatic logic [ACC_W-1:0] mulx(input logic [15:0] a, input logic [15:0] b);
        logic signed [ACC_W-1:0] xa, xb;
        xa = {{(ACC_W-16){a[15]}}, a};
        xb = {{(ACC_W-16){b[15]}}, b};
        return xa * xb;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s cycle=%0d act=%0h exp=%0h", tag, cyc, act, exp);
        end
    endtask

    task automatic clear_model();
        m_acc = '0; m_vld = 1'b0; m_done = 1'b0; r_sum = '0;
        q_rd = q_wr;
        for (int i = 0; i < 4; i++) begin
            h_v[i] = 1'b0; h_s[i] = 1'b0; h_e[i] = 1'b0; h_p[i] = '0;
        end
    endtask

    // One cycle: compare outputs, drive inputs, advance the model.
    task automatic step(input bit v, input bit s, input bit e, input logic [15:0] a, input logic [15:0] b);
        logic [ACC_W-1:0] p;
        @(negedge clk);
        check(acc_out == m_acc, "R4 R5 acc_out", 64'(acc_out), 64'(m_acc));
        check(acc_vld == m_vld, "R8 acc_vld", 64'(acc_vld), 64'(m_vld));
        check(seq_done == m_done, "R6 seq_done", 64'(seq_done), 64'(m_done));
        if (seq_done) begin
            if (q_rd != q_wr) begin
                check(acc_out == q_sum[q_rd % 64], "R3 R7 final sum", 64'(acc_out), 64'(q_sum[q_rd % 64]));
                check(cyc == q_cyc[q_rd % 64], "R2 R6 arrival cycle", 64'(cyc), 64'(q_cyc[q_rd % 64]));
                q_rd++;
            end else begin
                check(1'b0, "R6 unexpected done", 64'(1), 64'(0));
            end
        end
        in_vld = v; in_sos = s; in_eos = e; op_a = a; op_b = b;
        p = mulx(a, b);
        if (v) begin
            r_sum = s ? p : r_sum + p;
            if (e) begin
                q_sum[q_wr % 64] = r_sum;
                q_cyc[q_wr % 64] = cyc + 4;
                q_wr++;
            end
        end
        for (int i = 3; i > 0; i--) begin
            h_v[i] = h_v[i-1]; h_s[i] = h_s[i-1]; h_e[i] = h_e[i-1]; h_p[i] = h_p[i-1];
        end
        h_v[0] = v; h_s[0] = s; h_e[0] = e; h_p[0] = p;
        m_vld  = h_v[3];
        m_done = h_v[3] && h_e[3];
        if (h_v[3]) m_acc = h_s[3] ? h_p[3] : m_acc + h_p[3];
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            step(1'b0, 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
                 16'($urandom), 16'($urandom));
    endtask

    task automatic run_const(input int n, input logic [15:0] a, input logic [15:0] b);
        for (int i = 0; i < n; i++) step(1'b1, i == 0, i == n - 1, a, b);
    endtask

    // Random sequence; bub is the bubble chance in percent.
    task automatic run_rand(input int n, input int bub);
        for (int i = 0; i < n; i++) begin
            while (int'($urandom_range(99, 0)) < bub) idle(1);
            step(1'b1, i == 0, i == n - 1, 16'($urandom), 16'($urandom));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_vld = 1'b0; in_sos = 1'b0; in_eos = 1'b0;
        repeat (2) @(negedge clk);
        check(acc_out == '0, "R1 acc_out after reset", 64'(acc_out), 64'(0));
        check(!acc_vld, "R1 acc_vld after reset", 64'(acc_vld), 64'(0));
        check(!seq_done, "R1 seq_done after reset", 64'(seq_done), 64'(0));
        rst_n = 1'b1;
        clear_model();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog R2 act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_model();
        repeat (4) @(negedge clk);
        check(acc_out == '0 && !acc_vld && !seq_done, "R1 initial reset", 64'(acc_out), 64'(0));
        rst_n = 1'b1;
        // R8: valid pairs right after reset, acc_vld must wait four cycles.
        run_const(3, 16'h0003, 16'hFFFB);
        idle(6);
        // R9: single extreme product 2^30, and the other sign corners.
        run_const(1, 16'h8000, 16'h8000);
        run_const(1, 16'h8000, 16'h7FFF);
        run_const(1, 16'h7FFF, 16'h7FFF);
        run_const(1, 16'hFFFF, 16'h8000);
        idle(5);
        // R5: bubbles with stray markers inside a sequence.
        step(1'b1, 1'b1, 1'b0, 16'd100, 16'd7);
        idle(3);
        step(1'b1, 1'b0, 1'b0, 16'hFF9C, 16'd3);
        idle(2);
        step(1'b1, 1'b0, 1'b1, 16'd5, 16'd5);
        idle(6);
        // R7 R3: back-to-back sequences of 4, 2, 1, 1 with no gap.
        run_const(4, 16'd1000, 16'd1000);
        run_const(2, 16'hFC18, 16'd3);
        run_const(1, 16'd9, 16'd9);
        run_const(1, 16'hFFFE, 16'd4);
        idle(6);
        // R9: long runs that overflow 32 bits in both directions.
        run_const(300, 16'h8000, 16'h8000);
        run_const(300, 16'h8000, 16'h7FFF);
        idle(6);
        // Random sequences, random gaps (often none), random bubbles.
        for (int k = 0; k < 60; k++) begin
            run_rand(int'($urandom_range(40, 1)), (k % 3 == 0) ? 0 : 20);
            if ($urandom_range(1, 0) == 1) idle(int'($urandom_range(3, 0)));
        end
        idle(6);
        // R1: reset while a sequence is in flight, then a clean sequence.
        run_const(3, 16'd77, 16'd11);
        do_reset();
        run_const(5, 16'd12, 16'hFFF3);
        idle(8);
        check(q_rd == q_wr, "R6 every closed sequence signalled", 64'(q_rd), 64'(q_wr));
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule